// File: doc/BRIEF.md
# NEC Infrared Frame Decoder

This block turns the output of a demodulating infrared receiver (active low: the line is low while carrier is present) into NEC remote-control frames. The input is first synchronised and passed through a glitch filter. Each mark and each space is then measured in ticks of a programmable base time. A frame opens with a long leader mark and a leader space. A data frame then carries a number of pulse-distance bits, least significant first. The length of each bit period tells a 0 from a 1. When the leader space is short instead, the frame is a repeat code and carries no data.

Every measured duration is compared against its own programmable minimum/maximum window. A duration outside its window aborts the frame. A frame that runs past a programmable frame-time limit is also aborted. The block then returns to idle to wait for a fresh leader. A completed frame lands in a code register, and status flags report the result: valid, repeat, and byte-inversion errors on the address and command pairs. A one-cycle interrupt pulse marks each completion. A hold option keeps the first captured code until the host reads it. The host uses a small word-addressed register port with a one-cycle registered read.

Top module: `irnec_rx`

## Requirements
- R1: A tick lasts (BASE+1) microsecond periods, and a microsecond period is CLK_PER_US clock cycles. BASE is CFG[31:20]. All windows are counted in ticks.
- R2: The leader mark must measure within the LMARK window (address 1). A mark that is shorter or longer aborts the frame, and no status is set.
- R3: A leader space within the LSPACE window (address 2) starts data reception. A space that fits neither this window nor the repeat window aborts the frame.
- R4: A leader space within the RSPACE window (address 3) completes a repeat frame. STATUS[3:0] becomes 4'b1001 and the code register is left unchanged.
- R5: A bit period runs from the start of one mark to the start of the next. A period within the BIT0 window (address 4) gives 0, and one within the BIT1 window (address 5) gives 1. Bit n lands in CODE[n] (address 7), least significant first.
- R6: When CFG[15] (bit-1 match enable) is 0, only 0 periods are accepted. A 1 period then aborts the frame, while all-zero frames still decode.
- R7: CFG[13:8] holds the frame length minus one. A frame of N bits completes on the mark that follows bit N-1, and the CODE bits at N and above read 0.
- R8: The STATUS register (address 8) has these fields. Bit 3 is valid. Bit 2 is the data error, set when byte 3 is not the inverse of byte 2. Bit 1 is the custom error, set when byte 1 is not the inverse of byte 0. Bit 0 is repeat. Bit 7 is busy (decoder not idle) and bit 8 is the filtered input level (1 = mark).
- R9: A frame whose tick count since its leader began exceeds TIMEOUT (address 6) is aborted without setting status.
- R10: With CFG[14] (hold) set, a captured code stays in CODE until CODE is read. Later frames still update STATUS.
- R11: A level change on the input is accepted only once it has been stable for CFG[6:4]+1 clock cycles. Shorter pulses have no effect on decoding.
- R12: The irq output is high for exactly one cycle per completed data or repeat frame. A read of STATUS clears the valid bit.
- R13: After reset the registers hold their defaults. CFG = 0x01309F70, which means enable CFG[0]=0, filter 7, length 31, bit-1 match on, hold off and base 19. LMARK = 0x01F40190, with each window holding max in [28:16] and min in [12:0]. STATUS = 0 and irq is 0.
- R14: With CFG[0] clear, the decoder is held idle and decodes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_n | input | 1 | Demodulated receiver output, low during a mark |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_PER_US set to 1. It programs a base of 0 and windows scaled down about tenfold from the hardware defaults, so a tick is one clock. A full 32-bit frame then takes a few hundred cycles, and many frames, errors and aborts fit in a short run. The base is also reprogrammed to 1, with doubled symbol durations, to show that the windows follow the tick rather than the clock. The filter setting of 2 is small enough that a one-cycle glitch inside a leader space can be injected and must vanish.

// File: rtl/irnec_pkg.sv
package irnec_pkg;

  localparam int TW = 13;

  typedef logic [TW-1:0] dur_t;

  typedef struct packed {
    dur_t hi;
    dur_t lo;
  } win_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LMARK, ST_LSPACE, ST_DATA} rx_st_e;

  localparam logic [3:0] A_CFG     = 4'd0;
  localparam logic [3:0] A_LMARK   = 4'd1;
  localparam logic [3:0] A_LSPACE  = 4'd2;
  localparam logic [3:0] A_RSPACE  = 4'd3;
  localparam logic [3:0] A_BIT0    = 4'd4;
  localparam logic [3:0] A_BIT1    = 4'd5;
  localparam logic [3:0] A_TIMEOUT = 4'd6;
  localparam logic [3:0] A_CODE    = 4'd7;
  localparam logic [3:0] A_STAT    = 4'd8;

  function automatic logic in_win(dur_t v, win_t w);
    return (v >= w.lo) && (v <= w.hi);
  endfunction

  function automatic win_t win_of(logic [31:0] d);
    win_t w;
    w.hi = d[16 +: TW];
    w.lo = d[0 +: TW];
    return w;
  endfunction

  function automatic logic [31:0] win_word(win_t w);
    return {3'b000, w.hi, 3'b000, w.lo};
  endfunction

endpackage

// File: rtl/irnec_tick.sv
module irnec_tick #(
  parameter int CLK_PER_US = 50,
  parameter int BASE_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BASE_W-1:0] base,
  output logic              tick
);
  localparam int UW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic us_stb;

  generate
    if (CLK_PER_US == 1) begin : g_direct
      assign us_stb = 1'b1;
    end else begin : g_presc
      logic [UW-1:0] us_cnt;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          us_cnt <= '0;
        end else if (us_cnt == UW'(CLK_PER_US - 1)) begin
          us_cnt <= '0;
        end else begin
          us_cnt <= us_cnt + 1'b1;
        end
      end
      assign us_stb = (us_cnt == UW'(CLK_PER_US - 1));
    end
  endgenerate

  logic [BASE_W-1:0] base_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      base_cnt <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (us_stb) begin
        if (base_cnt >= base) begin
          base_cnt <= '0;
          tick     <= 1'b1;
        end else begin
          base_cnt <= base_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irnec_filter.sv
module irnec_filter #(
  parameter int FILT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_n,
  input  logic [FILT_W-1:0] thr,
  output logic              mark
);
  logic s1, s2;
  logic [FILT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      cnt  <= '0;
      mark <= 1'b0;
    end else begin
      s1 <= ~ir_n;
      s2 <= s1;
      if (s2 == mark) begin
        cnt <= '0;
      end else if (cnt >= thr) begin
        mark <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irnec_fsm.sv
module irnec_fsm
  import irnec_pkg::*;
#(
  parameter int CODE_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              mark,
  input  logic              bit1_en,
  input  logic [LEN_W-1:0]  len_m1,
  input  dur_t              frame_to,
  input  win_t              w_lm,
  input  win_t              w_ls,
  input  win_t              w_rs,
  input  win_t              w_b0,
  input  win_t              w_b1,
  output logic              busy,
  output logic              frame_done,
  output logic              rpt_done,
  output logic [CODE_W-1:0] code
);
  localparam int   IX   = $clog2(CODE_W);
  localparam dur_t DMAX = '1;

  rx_st_e            state;
  dur_t              dur, fcnt, dur_n, fcnt_n;
  logic              mark_q, rise, fall;
  logic [LEN_W-1:0]  bitcnt;
  logic              bit_ok, bit_val, to_hit;
  dur_t              data_max;

  always_comb begin
    rise     = mark && !mark_q;
    fall     = !mark && mark_q;
    dur_n    = (tick && dur != DMAX) ? dur + 1'b1 : dur;
    fcnt_n   = (tick && fcnt != DMAX) ? fcnt + 1'b1 : fcnt;
    to_hit   = fcnt > frame_to;
    data_max = bit1_en ? w_b1.hi : w_b0.hi;
    bit_val  = 1'b0;
    bit_ok   = 1'b0;
    if (in_win(dur, w_b0)) begin
      bit_ok = 1'b1;
    end else if (bit1_en && in_win(dur, w_b1)) begin
      bit_ok  = 1'b1;
      bit_val = 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dur        <= '0;
      fcnt       <= '0;
      mark_q     <= 1'b0;
      bitcnt     <= '0;
      code       <= '0;
      frame_done <= 1'b0;
      rpt_done   <= 1'b0;
    end else begin
      mark_q     <= mark;
      frame_done <= 1'b0;
      rpt_done   <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        dur   <= '0;
        fcnt  <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            dur  <= '0;
            fcnt <= '0;
            if (rise) state <= ST_LMARK;
          end
          ST_LMARK: begin
            dur  <= dur_n;
            fcnt <= fcnt_n;
            if (to_hit) begin
              state <= ST_IDLE;
            end else if (fall) begin
              dur   <= '0;
              state <= in_win(dur, w_lm) ? ST_LSPACE : ST_IDLE;
            end else if (dur > w_lm.hi) begin
              state <= ST_IDLE;
            end
          end
          ST_LSPACE: begin
            dur  <= dur_n;
            fcnt <= fcnt_n;
            if (to_hit) begin
              state <= ST_IDLE;
            end else if (rise) begin
              dur <= '0;
              if (in_win(dur, w_ls)) begin
                state  <= ST_DATA;
                bitcnt <= '0;
                code   <= '0;
              end else begin
                rpt_done <= in_win(dur, w_rs);
                state    <= ST_IDLE;
              end
            end else if (dur > w_ls.hi && dur > w_rs.hi) begin
              state <= ST_IDLE;
            end
          end
          ST_DATA: begin
            dur  <= dur_n;
            fcnt <= fcnt_n;
            if (to_hit) begin
              state <= ST_IDLE;
            end else if (rise) begin
              dur <= '0;
              if (!bit_ok) begin
                state <= ST_IDLE;
              end else begin
                code[bitcnt[IX-1:0]] <= bit_val;
                if (bitcnt == len_m1) begin
                  frame_done <= 1'b1;
                  state      <= ST_IDLE;
                end else begin
                  bitcnt <= bitcnt + 1'b1;
                end
              end
            end else if (dur > data_max) begin
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irnec_rx.sv
module irnec_rx
  import irnec_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int BASE_W     = 12,
  parameter int FILT_W     = 3,
  parameter int LEN_W      = 6,
  parameter int DEF_BASE   = 19,
  parameter int DEF_FILT   = 7,
  parameter int DEF_LEN    = 31,
  parameter int DEF_TO     = 4000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ir_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int   CODE_W = 32;
  localparam win_t DEF_LM = '{hi: dur_t'(500), lo: dur_t'(400)};
  localparam win_t DEF_LS = '{hi: dur_t'(300), lo: dur_t'(200)};
  localparam win_t DEF_RS = '{hi: dur_t'(150), lo: dur_t'(80)};
  localparam win_t DEF_B0 = '{hi: dur_t'(72),  lo: dur_t'(40)};
  localparam win_t DEF_B1 = '{hi: dur_t'(134), lo: dur_t'(90)};

  logic              cfg_en, cfg_hold, cfg_b1;
  logic [FILT_W-1:0] cfg_filt;
  logic [LEN_W-1:0]  cfg_len;
  logic [BASE_W-1:0] cfg_base;
  win_t              w_lm, w_ls, w_rs, w_b0, w_b1;
  dur_t              frame_to;

  logic              tick, mark, busy, frame_done, rpt_done;
  logic [CODE_W-1:0] fsm_code, code_r;
  logic              held, st_valid, st_derr, st_cerr, st_rpt, irq_r;
  logic [31:0]       cfg_rd, stat_rd;
  logic              rd_code, rd_stat;

  irnec_tick #(.CLK_PER_US(CLK_PER_US), .BASE_W(BASE_W)) u_tick (
    .clk(clk), .rst(rst), .en(cfg_en), .base(cfg_base), .tick(tick)
  );

  irnec_filter #(.FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst(rst), .ir_n(ir_n), .thr(cfg_filt), .mark(mark)
  );

  irnec_fsm #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .en(cfg_en), .tick(tick), .mark(mark),
    .bit1_en(cfg_b1), .len_m1(cfg_len), .frame_to(frame_to),
    .w_lm(w_lm), .w_ls(w_ls), .w_rs(w_rs), .w_b0(w_b0), .w_b1(w_b1),
    .busy(busy), .frame_done(frame_done), .rpt_done(rpt_done), .code(fsm_code)
  );

  assign rd_code = reg_rd && (reg_addr == A_CODE);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en   <= 1'b0;
      cfg_hold <= 1'b0;
      cfg_b1   <= 1'b1;
      cfg_filt <= FILT_W'(DEF_FILT);
      cfg_len  <= LEN_W'(DEF_LEN);
      cfg_base <= BASE_W'(DEF_BASE);
      w_lm     <= DEF_LM;
      w_ls     <= DEF_LS;
      w_rs     <= DEF_RS;
      w_b0     <= DEF_B0;
      w_b1     <= DEF_B1;
      frame_to <= dur_t'(DEF_TO);
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG: begin
          cfg_en   <= reg_wdata[0];
          cfg_filt <= reg_wdata[4 +: FILT_W];
          cfg_len  <= reg_wdata[8 +: LEN_W];
          cfg_hold <= reg_wdata[14];
          cfg_b1   <= reg_wdata[15];
          cfg_base <= reg_wdata[20 +: BASE_W];
        end
        A_LMARK:   w_lm     <= win_of(reg_wdata);
        A_LSPACE:  w_ls     <= win_of(reg_wdata);
        A_RSPACE:  w_rs     <= win_of(reg_wdata);
        A_BIT0:    w_b0     <= win_of(reg_wdata);
        A_BIT1:    w_b1     <= win_of(reg_wdata);
        A_TIMEOUT: frame_to <= reg_wdata[0 +: TW];
        default: ;
      endcase
    end
  end

  // capture, status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      code_r   <= '0;
      held     <= 1'b0;
      st_valid <= 1'b0;
      st_derr  <= 1'b0;
      st_cerr  <= 1'b0;
      st_rpt   <= 1'b0;
      irq_r    <= 1'b0;
    end else begin
      irq_r <= frame_done || rpt_done;
      if (rd_code) held <= 1'b0;
      if (rd_stat) st_valid <= 1'b0;
      if (frame_done) begin
        if (!(cfg_hold && held)) begin
          code_r <= fsm_code;
          held   <= cfg_hold;
        end
        st_valid <= 1'b1;
        st_rpt   <= 1'b0;
        st_cerr  <= fsm_code[15:8]  != ~fsm_code[7:0];
        st_derr  <= fsm_code[31:24] != ~fsm_code[23:16];
      end else if (rpt_done) begin
        st_valid <= 1'b1;
        st_rpt   <= 1'b1;
        st_cerr  <= 1'b0;
        st_derr  <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rd                 = '0;
    cfg_rd[0]              = cfg_en;
    cfg_rd[4 +: FILT_W]    = cfg_filt;
    cfg_rd[8 +: LEN_W]     = cfg_len;
    cfg_rd[14]             = cfg_hold;
    cfg_rd[15]             = cfg_b1;
    cfg_rd[20 +: BASE_W]   = cfg_base;
    stat_rd                = {23'd0, mark, busy, 3'd0, st_valid, st_derr, st_cerr, st_rpt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CFG:     reg_rdata <= cfg_rd;
        A_LMARK:   reg_rdata <= win_word(w_lm);
        A_LSPACE:  reg_rdata <= win_word(w_ls);
        A_RSPACE:  reg_rdata <= win_word(w_rs);
        A_BIT0:    reg_rdata <= win_word(w_b0);
        A_BIT1:    reg_rdata <= win_word(w_b1);
        A_TIMEOUT: reg_rdata <= {{(32-TW){1'b0}}, frame_to};
        A_CODE:    reg_rdata <= code_r;
        A_STAT:    reg_rdata <= stat_rd;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_r;
endmodule

// File: rtl/irnec_rx_chk.sv
module irnec_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        busy,
  input logic        en,
  input logic        st_valid,
  input logic        st_rpt,
  input logic        st_cerr,
  input logic        st_derr,
  input logic        held,
  input logic        hold_en,
  input logic [31:0] code_r,
  input logic        rd_code,
  input logic        rd_stat,
  input logic        reg_wr,
  input logic        frame_done,
  input logic        rpt_done
);
  p_irq_single_r12: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_valid_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_valid);

  p_rd_clears_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !frame_done && !rpt_done) |=> !st_valid);

  p_rpt_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    st_rpt |-> (!st_cerr && !st_derr));

  p_hold_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (held && hold_en && !rd_code && !reg_wr) |=> $stable(code_r));

  p_rpt_code_r4: assert property (@(posedge clk) disable iff (rst)
    rpt_done |=> $stable(code_r));

  p_disable_idle_r14: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy);
endmodule

bind irnec_rx irnec_rx_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .busy(busy), .en(cfg_en),
  .st_valid(st_valid), .st_rpt(st_rpt), .st_cerr(st_cerr), .st_derr(st_derr),
  .held(held), .hold_en(cfg_hold), .code_r(code_r), .rd_code(rd_code),
  .rd_stat(rd_stat), .reg_wr(reg_wr), .frame_done(frame_done), .rpt_done(rpt_done)
);

// File: tb/irnec_rx_bench.sv
`timescale 1ns/1ps
module irnec_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_n = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;

  always #10 clk = ~clk;

  irnec_rx #(.CLK_PER_US(1)) u_irnec_rx (
    .clk(clk), .rst(rst), .ir_n(ir_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  localparam logic [31:0] VEC [0:4] = '{
    32'hF708FB04, 32'h00FF00FF, 32'h12345678, 32'hEF10AA55, 32'h0000FE01
  };

  function automatic logic [31:0] cfg_word(int base, bit b1, bit hold, int len, int filt, bit en);
    return (32'(base) << 20) | (32'(b1) << 15) | (32'(hold) << 14) |
           (32'(len) << 8) | (32'(filt) << 4) | 32'(en);
  endfunction

  function automatic logic [3:0] exp_stat(logic [31:0] c);
    return {1'b1, c[31:24] != ~c[23:16], c[15:8] != ~c[7:0], 1'b0};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic mk(input int n);
    ir_n = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sp(input int n);
    ir_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] c, input int nb, input int lm, input int ls,
                      input int sc, input bit gl);
    @(negedge clk);
    mk(lm * sc);
    if (gl) begin
      sp(10); mk(1); sp(ls - 11);
    end else begin
      sp(ls * sc);
    end
    for (int i = 0; i < nb; i++) begin
      mk(3 * sc);
      sp((c[i] ? 8 : 3) * sc);
    end
    mk(3 * sc);
    sp(40 * sc);
  endtask

  task automatic send_rpt(input int ls);
    @(negedge clk);
    mk(45); sp(ls); mk(3); sp(40);
  endtask

  task automatic setup(input int base, input bit b1, input bit hold, input int len, input int to);
    wr(4'd0, cfg_word(base, b1, hold, len, 2, 1'b1));
    wr(4'd6, 32'(to));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] last;
    int ic;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset defaults
    chk({31'd0, irq}, 32'd0, "R13 irq after reset");
    rd(4'd0, d); chk(d, 32'h01309F70, "R13 CFG default");
    rd(4'd1, d); chk(d, 32'h01F40190, "R13 LMARK default");
    rd(4'd8, d); chk(d, 32'h0, "R13 STATUS default");

    // scaled windows, one tick per clock
    wr(4'd1, (32'd50 << 16) | 32'd40);
    wr(4'd2, (32'd30 << 16) | 32'd20);
    wr(4'd3, (32'd15 << 16) | 32'd8);
    wr(4'd4, (32'd7  << 16) | 32'd4);
    wr(4'd5, (32'd13 << 16) | 32'd9);
    setup(0, 1, 0, 31, 600);

    // R5 / R8 / R12 table walk
    for (int k = 0; k < 5; k++) begin
      ic = irq_cnt;
      send(VEC[k], 32, 45, 25, 1, 0);
      chk(32'(irq_cnt - ic), 32'd1, "R12 one irq per frame");
      rd(4'd8, d); chk({28'd0, d[3:0]}, {28'd0, exp_stat(VEC[k])}, "R8 status");
      rd(4'd7, d); chk(d, VEC[k], "R5 code LSB first");
      rd(4'd8, d); chk({31'd0, d[3]}, 32'd0, "R12 valid cleared by read");
    end
    last = VEC[4];

    // R4 repeat
    ic = irq_cnt;
    send_rpt(11);
    chk(32'(irq_cnt - ic), 32'd1, "R4 repeat irq");
    rd(4'd8, d); chk({28'd0, d[3:0]}, 32'h9, "R4 repeat status");
    rd(4'd7, d); chk(d, last, "R4 code unchanged");

    // R2 leader mark out of window
    ic = irq_cnt;
    send(VEC[0], 32, 30, 25, 1, 0);
    send(VEC[0], 32, 60, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R2 bad leader mark aborts");
    rd(4'd8, d); chk({31'd0, d[3]}, 32'd0, "R2 no valid after abort");

    // R3 space between repeat and leader windows
    ic = irq_cnt;
    send(VEC[0], 32, 45, 18, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R3 bad leader space aborts");

    // R6 bit-1 match disabled
    setup(0, 0, 0, 31, 600);
    ic = irq_cnt;
    send(32'h0, 32, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd1, "R6 zeros decode");
    rd(4'd8, d); chk({28'd0, d[3:0]}, 32'hE, "R6 zero frame status");
    rd(4'd7, d); chk(d, 32'h0, "R6 zero frame code");
    ic = irq_cnt;
    send(VEC[0], 32, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R6 one period aborts");

    // R7 16-bit frame
    setup(0, 1, 0, 15, 600);
    ic = irq_cnt;
    send(32'h0000F50A, 16, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd1, "R7 short frame irq");
    rd(4'd7, d); chk(d, 32'h0000F50A, "R7 short frame code");
    rd(4'd8, d); chk({28'd0, d[3:0]}, 32'hC, "R7 short frame status");

    // R9 frame timeout
    setup(0, 1, 0, 31, 200);
    ic = irq_cnt;
    send(VEC[0], 32, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R9 timeout aborts");
    rd(4'd8, d); chk({31'd0, d[7]}, 32'd0, "R9 idle after timeout");

    // R10 hold until read
    setup(0, 1, 1, 31, 600);
    send(VEC[0], 32, 45, 25, 1, 0);
    send(VEC[2], 32, 45, 25, 1, 0);
    rd(4'd8, d); chk({28'd0, d[3:0]}, {28'd0, exp_stat(VEC[2])}, "R10 status follows new frame");
    rd(4'd7, d); chk(d, VEC[0], "R10 first code held");
    send(VEC[2], 32, 45, 25, 1, 0);
    rd(4'd7, d); chk(d, VEC[2], "R10 capture after read");

    // R11 glitch filter
    setup(0, 1, 0, 31, 600);
    ic = irq_cnt;
    send(VEC[3], 32, 45, 25, 1, 1);
    chk(32'(irq_cnt - ic), 32'd1, "R11 glitch ignored");
    rd(4'd7, d); chk(d, VEC[3], "R11 code with glitch");
    @(negedge clk);
    ir_n = 1'b0;
    repeat (20) @(negedge clk);
    rd(4'd8, d);
    chk({31'd0, d[8]}, 32'd1, "R11 level bit shows mark");
    chk({31'd0, d[7]}, 32'd1, "R8 busy during leader");
    ir_n = 1'b1;
    repeat (60) @(negedge clk);
    rd(4'd8, d); chk({31'd0, d[7]}, 32'd0, "R2 short mark back to idle");

    // R1 base time scaling
    setup(1, 1, 0, 31, 600);
    ic = irq_cnt;
    send(VEC[1], 32, 45, 25, 2, 0);
    chk(32'(irq_cnt - ic), 32'd1, "R1 doubled durations decode");
    rd(4'd7, d); chk(d, VEC[1], "R1 code at base 1");
    ic = irq_cnt;
    send(VEC[0], 32, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R1 unscaled durations rejected");

    // R14 disabled
    wr(4'd0, cfg_word(0, 1, 0, 31, 2, 1'b0));
    ic = irq_cnt;
    send(VEC[0], 32, 45, 25, 1, 0);
    chk(32'(irq_cnt - ic), 32'd0, "R14 disabled decodes nothing");
    rd(4'd8, d); chk({31'd0, d[7]}, 32'd0, "R14 idle while disabled");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule